// File: doc/BRIEF.md
# Pretrigger Capture Engine

This block turns a free-running 8-bit converter bus into one frame of paced samples held in a register array, arranged so that a rising-edge trigger event sits at a column chosen by the user. Samples arrive at an interval set by a time-base code. Before the trigger, the samples ahead of the chosen column form a sliding history window. Each new sample that does not trigger moves that window one slot toward index 0. The trigger sample is pinned at the chosen column, and the columns after it fill with the samples that follow.

Once a frame is complete, the block raises a copy request. It holds the array frozen until a downstream display buffer accepts it. It then waits for a hold-off interval before it re-arms. In single mode it stays parked after the hold-off until the mode changes or the block is restarted. The run/stop input and a settings-changed pulse both restart the engine from its idle state at any time.

The converter bus needs time to settle after each conversion, so the block latches it on the falling clock edge. All control runs on the rising edge.

Top module: `pretrig_capture`

## Requirements
- R1: The sample interval is set by `tb_code` k (0 = 1 us per division up to 5 = 100 ms per division; codes 6 and 7 act as 5). The interval in clock cycles is round(CLK_HZ × 10^k × 10 / (10^6 × DEPTH)), with a minimum of 1. The code is read only when the engine arms.
- R2: Every paced sample is the value present on `adc_data` at the falling clock edge just before the rising edge that consumes it.
- R3: After arming, while the write index is below the trigger column, each paced sample is written at the write index and the index moves up by one.
- R4: Once the index has reached the trigger column, a sample that does not trigger moves every array slot one place toward index 0, and the new sample is then written at column − 1. With column 0 such a sample is discarded.
- R5: A trigger is a paced sample at or above the level whose predecessor, also taken since arming, is below the level. That sample is written at the trigger column.
- R6: After the trigger, paced samples fill the columns above the trigger column up to DEPTH−1, and the engine then requests a copy. With trigger column DEPTH−1 the copy request follows the trigger sample directly.
- R7: `copy_valid` is high only in the copy state. While `copy_ready` is low, the array and the state hold. A cycle with both signals high moves the engine to hold-off.
- R8: Hold-off lasts HOLDOFF cycles and then returns to idle when `single_mode` is low. When `single_mode` is high, the engine stays in hold-off until that input falls or a restart occurs.
- R9: `run_stop` high or `cfg_chg` high moves the engine to idle at the next rising edge and clears the pacing counter, write index and previous-sample record. The engine stays idle while `run_stop` stays high.
- R10: `state` encodes idle = 0, counting = 1, triggered = 2, copy = 3, hold-off = 4. The trigger level and trigger column are captured in idle, and a column above DEPTH−1 is treated as DEPTH−1.
- R11: The asynchronous active-low reset gives state 0, an all-zero array and `copy_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; control on the rising edge, converter latch on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_data | input | DW | Converter output bus |
| tb_code | input | 3 | Time-base code |
| trig_level | input | DW | Trigger level |
| trig_col | input | clog2(DEPTH) | Array column that receives the trigger sample |
| single_mode | input | 1 | 1 = park after hold-off, 0 = free run |
| run_stop | input | 1 | 1 = stopped, held in idle |
| cfg_chg | input | 1 | One-cycle pulse when settings change; restarts the engine |
| samples | output | DEPTH×DW | Sample array, slot i at bits i×DW upward |
| state | output | 3 | Engine state code |
| copy_valid | output | 1 | Frame ready to copy; array frozen |
| copy_ready | input | 1 | Display buffer accepts the frame |

## Verification
The bench builds the block with DEPTH = 12, CLK_HZ = 1,200,000 and HOLDOFF = 40. With these values, time-base codes 0 and 1 give sample intervals of 1 and 10 cycles, so a whole frame, including the sliding pretrigger phase, takes a few hundred to about a thousand cycles. A 12-slot array makes the column-0, last-column and out-of-range-column cases cheap to reach. Because 12 is not a power of two, a column value above the last slot can be driven at all. The short hold-off lets the bench count the free-run hold-off exactly and watch single mode stay parked for several hold-off lengths. The converter input carries the wanted value only around each falling edge, so a design that latched on the rising edge would capture inverted data.

// File: rtl/cap_pkg.sv
package cap_pkg;

  typedef enum logic [2:0] {
    ST_INIT  = 3'd0,
    ST_COUNT = 3'd1,
    ST_TRIG  = 3'd2,
    ST_COPY  = 3'd3,
    ST_HOLD  = 3'd4
  } cap_state_e;

  localparam int unsigned TB_CODES = 6;

  // Cycles between samples for time-base code k: 10^k us per division,
  // ten divisions spread across the array, rounded to nearest, at least 1.
  function automatic longint unsigned pace_cycles(longint unsigned clk_hz,
                                                  longint unsigned depth,
                                                  int unsigned     code);
    longint unsigned num;
    longint unsigned den;
    longint unsigned q;
    num = clk_hz * 10;
    for (int unsigned i = 0; i < code; i++) num = num * 10;
    den = 64'd1_000_000 * depth;
    q = (num + den / 2) / den;
    if (q == 0) q = 1;
    return q;
  endfunction

endpackage

// File: rtl/pace_timer.sv
module pace_timer #(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned DEPTH  = 640
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [2:0] code,
  input  logic       run,
  output logic       tick
);
  import cap_pkg::*;

  localparam longint unsigned PER0 = pace_cycles(CLK_HZ, DEPTH, 0);
  localparam longint unsigned PER1 = pace_cycles(CLK_HZ, DEPTH, 1);
  localparam longint unsigned PER2 = pace_cycles(CLK_HZ, DEPTH, 2);
  localparam longint unsigned PER3 = pace_cycles(CLK_HZ, DEPTH, 3);
  localparam longint unsigned PER4 = pace_cycles(CLK_HZ, DEPTH, 4);
  localparam longint unsigned PER5 = pace_cycles(CLK_HZ, DEPTH, TB_CODES - 1);
  localparam int unsigned CW = $clog2(PER5 + 1);

  logic [CW-1:0] per_q;
  logic [CW-1:0] per_sel;
  logic [CW-1:0] cnt_q;

  always_comb begin
    case (code)
      3'd0:    per_sel = CW'(PER0);
      3'd1:    per_sel = CW'(PER1);
      3'd2:    per_sel = CW'(PER2);
      3'd3:    per_sel = CW'(PER3);
      3'd4:    per_sel = CW'(PER4);
      default: per_sel = CW'(PER5);
    endcase
  end

  assign tick = run && !load && (cnt_q == per_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= CW'(1);
      cnt_q <= '0;
    end else if (load) begin
      per_q <= per_sel;
      cnt_q <= '0;
    end else if (run) begin
      if (tick) cnt_q <= '0;
      else      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R1: with an interval above one cycle, two ticks never come back to back
  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && per_q > CW'(1)) |=> !tick);

endmodule

// File: rtl/trig_detect.sv
module trig_detect #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          smp_en,
  input  logic [DW-1:0] sample,
  input  logic [DW-1:0] level,
  output logic          hit
);
  logic [DW-1:0] prev_q;
  logic          prev_vld_q;

  assign hit = smp_en && prev_vld_q && (prev_q < level) && (sample >= level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q     <= '0;
      prev_vld_q <= 1'b0;
    end else if (clr) begin
      prev_q     <= '0;
      prev_vld_q <= 1'b0;
    end else if (smp_en) begin
      prev_q     <= sample;
      prev_vld_q <= 1'b1;
    end
  end

  // R5: the predecessor used for the crossing is the last paced sample
  assert_prev_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && !clr) |=> (prev_vld_q && prev_q == $past(sample)));

  // R9: a clear forgets the predecessor
  assert_prev_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !hit);

endmodule

// File: rtl/shift_array.sv
module shift_array #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 640
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     shift_en,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [DW-1:0]            wr_data,
  output logic [DEPTH*DW-1:0]      samples
);
  localparam int unsigned AW = $clog2(DEPTH);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [DW-1:0] q;
    logic [DW-1:0] right;
    if (i < DEPTH - 1) begin : g_mid
      assign right = samples[(i+1)*DW +: DW];
    end else begin : g_top
      assign right = q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  q <= '0;
      else if (wr_en && wr_addr == AW'(i))         q <= wr_data;
      else if (shift_en)                           q <= right;
    end
    assign samples[i*DW +: DW] = q;
  end

  // R4: a slide moves slot 1 into slot 0 unless slot 0 is being written
  assert_slide_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !(wr_en && wr_addr == '0)) |=>
      (samples[DW-1:0] == $past(samples[2*DW-1:DW])));

  // R7: without a write or slide the array keeps its contents
  assert_idle_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !wr_en) |=> $stable(samples));

endmodule

// File: rtl/pretrig_capture.sv
module pretrig_capture #(
  parameter int unsigned DW      = 8,
  parameter int unsigned DEPTH   = 640,
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned HOLDOFF = 10_000_000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DW-1:0]            adc_data,
  input  logic [2:0]               tb_code,
  input  logic [DW-1:0]            trig_level,
  input  logic [$clog2(DEPTH)-1:0] trig_col,
  input  logic                     single_mode,
  input  logic                     run_stop,
  input  logic                     cfg_chg,
  output logic [DEPTH*DW-1:0]      samples,
  output logic [2:0]               state,
  output logic                     copy_valid,
  input  logic                     copy_ready
);
  import cap_pkg::*;

  localparam int unsigned COLW = $clog2(DEPTH);
  localparam int unsigned HW   = $clog2(HOLDOFF + 1);
  localparam logic [COLW-1:0] LAST_COL = COLW'(DEPTH - 1);
  localparam logic [HW-1:0]   HOLD_END = HW'(HOLDOFF - 1);

  cap_state_e     st_q;
  logic [DW-1:0]  adc_q;
  logic [DW-1:0]  lvl_q;
  logic [COLW-1:0] col_q;
  logic [COLW-1:0] idx_q;
  logic [HW-1:0]  hold_q;

  logic            restart;
  logic            tick;
  logic            hit;
  logic            wr_en;
  logic            shift_en;
  logic [COLW-1:0] wr_addr;

  assign restart = run_stop || cfg_chg;

  // converter bus latched mid-cycle, after it has settled
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) adc_q <= '0;
    else        adc_q <= adc_data;
  end

  pace_timer #(.CLK_HZ(CLK_HZ), .DEPTH(DEPTH)) u_pace (
    .clk  (clk),
    .rst_n(rst_n),
    .load (restart || st_q == ST_INIT),
    .code (tb_code),
    .run  (st_q == ST_COUNT || st_q == ST_TRIG),
    .tick (tick)
  );

  trig_detect #(.DW(DW)) u_det (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (restart || st_q == ST_INIT),
    .smp_en(tick),
    .sample(adc_q),
    .level (lvl_q),
    .hit   (hit)
  );

  shift_array #(.DW(DW), .DEPTH(DEPTH)) u_arr (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(shift_en),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (adc_q),
    .samples (samples)
  );

  // array write / slide selection for the current paced sample
  always_comb begin
    wr_en    = 1'b0;
    shift_en = 1'b0;
    wr_addr  = idx_q;
    if (!restart && tick) begin
      if (st_q == ST_COUNT) begin
        if (idx_q < col_q) begin
          wr_en = 1'b1;
        end else if (hit) begin
          wr_en   = 1'b1;
          wr_addr = col_q;
        end else if (col_q != '0) begin
          shift_en = 1'b1;
          wr_en    = 1'b1;
          wr_addr  = col_q - 1'b1;
        end
      end else if (st_q == ST_TRIG) begin
        wr_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_INIT;
      lvl_q  <= '0;
      col_q  <= '0;
      idx_q  <= '0;
      hold_q <= '0;
    end else if (restart) begin
      st_q   <= ST_INIT;
      idx_q  <= '0;
      hold_q <= '0;
    end else begin
      case (st_q)
        ST_INIT: begin
          lvl_q  <= trig_level;
          col_q  <= (trig_col > LAST_COL) ? LAST_COL : trig_col;
          idx_q  <= '0;
          hold_q <= '0;
          st_q   <= ST_COUNT;
        end
        ST_COUNT: begin
          if (tick) begin
            if (idx_q < col_q) begin
              idx_q <= idx_q + 1'b1;
            end else if (hit) begin
              if (col_q == LAST_COL) begin
                st_q <= ST_COPY;
              end else begin
                idx_q <= col_q + 1'b1;
                st_q  <= ST_TRIG;
              end
            end
          end
        end
        ST_TRIG: begin
          if (tick) begin
            if (idx_q == LAST_COL) st_q <= ST_COPY;
            else                   idx_q <= idx_q + 1'b1;
          end
        end
        ST_COPY: begin
          if (copy_ready) begin
            st_q   <= ST_HOLD;
            hold_q <= '0;
          end
        end
        ST_HOLD: begin
          if (hold_q == HOLD_END) begin
            if (!single_mode) st_q <= ST_INIT;
          end else begin
            hold_q <= hold_q + 1'b1;
          end
        end
        default: st_q <= ST_INIT;
      endcase
    end
  end

  assign state      = st_q;
  assign copy_valid = (st_q == ST_COPY);

  // R9: restart always lands in idle
  assert_restart_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (state == 3'd0));

  // R7: back-pressure freezes state and array
  assert_copy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_valid && !copy_ready && !restart) |=> (copy_valid && $stable(samples)));

  // R8: single mode stays parked in hold-off
  assert_single_park_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD && single_mode && !restart) |=> (st_q == ST_HOLD));

  // R5: entering triggered leaves a value at or above the level in the trigger column
  assert_trig_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TRIG && $past(st_q) == ST_COUNT) |->
      (samples[int'(col_q)*DW +: DW] >= lvl_q));

endmodule

// File: tb/test_pretrig_capture.sv
`timescale 1ns/100ps
module test_pretrig_capture;
  localparam int DW      = 8;
  localparam int DEPTH   = 12;
  localparam int CLK_HZ  = 1_200_000;
  localparam int HOLDOFF = 40;
  localparam int COLW    = $clog2(DEPTH);
  localparam int SEQ_N   = 200;
  localparam int LEAD    = DEPTH + 4;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic [DW-1:0]        adc_data;
  logic [2:0]           tb_code;
  logic [DW-1:0]        trig_level;
  logic [COLW-1:0]      trig_col;
  logic                 single_mode;
  logic                 run_stop;
  logic                 cfg_chg;
  logic [DEPTH*DW-1:0]  samples;
  logic [2:0]           state;
  logic                 copy_valid;
  logic                 copy_ready;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  int seq [SEQ_N];

  always #2.5 clk = ~clk;

  pretrig_capture #(.DW(DW), .DEPTH(DEPTH), .CLK_HZ(CLK_HZ), .HOLDOFF(HOLDOFF)) i_pretrig_capture (
    .clk(clk), .rst_n(rst_n), .adc_data(adc_data), .tb_code(tb_code),
    .trig_level(trig_level), .trig_col(trig_col), .single_mode(single_mode),
    .run_stop(run_stop), .cfg_chg(cfg_chg), .samples(samples), .state(state),
    .copy_valid(copy_valid), .copy_ready(copy_ready)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // interval from the time-base rule
  function automatic int per_of(input int code);
    longint num = longint'(CLK_HZ) * 10;
    longint den = longint'(1_000_000) * DEPTH;
    longint q;
    for (int i = 0; i < code; i++) num = num * 10;
    q = (num + den / 2) / den;
    return (q < 1) ? 1 : int'(q);
  endfunction

  function automatic void build(input int kind, input int step);
    for (int k = 0; k < SEQ_N; k++) begin
      if (k < LEAD) seq[k] = 0;
      else if (kind == 0) seq[k] = ((k - LEAD) * step) % 256;
      else seq[k] = int'(128.0 + 127.0 * $sin(2.0 * 3.14159265 * (k - LEAD) / 24.0));
    end
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Runs one frame; returns with the design in hold-off.
  task automatic capture(input int code, input int col_in, input int lvl,
                         input bit single, input bit meas_hold, input string tag);
    int col, j, per, bad, first, nh;
    bit got;
    logic [DEPTH*DW-1:0] snap;
    col = (col_in > DEPTH - 1) ? DEPTH - 1 : col_in;
    j = -1;
    for (int k = 1; k < SEQ_N; k++)
      if (j < 0 && seq[k-1] < lvl && seq[k] >= lvl) j = k;
    per = per_of(code);
    @(posedge clk); #1;
    tb_code = 3'(code); trig_level = DW'(lvl); trig_col = COLW'(col_in);
    single_mode = single; cfg_chg = 1'b1;
    @(posedge clk); #1 cfg_chg = 1'b0;
    got = 1'b0;
    for (int k = 0; k < SEQ_N && !got; k++) begin
      for (int r = 0; r < per && !got; r++) begin
        @(posedge clk);
        #1 adc_data = ~DW'(seq[k]);
        #1 adc_data = DW'(seq[k]);   // valid only around the falling edge (R2)
        #1 adc_data = ~DW'(seq[k]);
        #1 if (copy_valid) got = 1'b1;
      end
    end
    adc_data = '0;
    check(got, tag, "copy request after frame (R6)", longint'(got), 1);
    bad = 0; first = 0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (samples[i*DW +: DW] != DW'(seq[j - col + i])) begin bad++; first = i; end
    check(bad == 0, tag, $sformatf("frame slot %0d (R2 R3 R4)", first),
          longint'(samples[first*DW +: DW]), longint'(seq[j - col + first]));
    check(samples[col*DW +: DW] == DW'(seq[j]), "R5", $sformatf("trigger column %0d value", col),
          longint'(samples[col*DW +: DW]), longint'(seq[j]));
    // back-pressure
    snap = samples;
    repeat (3) @(posedge clk);
    #1;
    check(state == 3'd3 && copy_valid, "R7", "state while copy not accepted", longint'(state), 3);
    check(samples == snap, "R7", "array stable under back-pressure", 0, 0);
    copy_ready = 1'b1;
    @(posedge clk); #1 copy_ready = 1'b0;
    check(state == 3'd4 && !copy_valid, "R7", "state after accept", longint'(state), 4);
    if (meas_hold) begin
      nh = 0;
      while (state == 3'd4 && nh < 1000) begin nh++; @(posedge clk); #1; end
      check(nh == HOLDOFF, "R8", "free-run hold-off cycles", nh, HOLDOFF);
      check(state == 3'd0, "R8", "state after hold-off", longint'(state), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    rst_n = 1'b0; adc_data = '0; tb_code = '0; trig_level = 8'd100; trig_col = '0;
    single_mode = 1'b0; run_stop = 1'b1; cfg_chg = 1'b0; copy_ready = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(state == 3'd0, "R11", "state in reset", longint'(state), 0);
    check(samples == '0, "R11", "array in reset", 0, 0);
    check(!copy_valid, "R11", "copy_valid in reset", longint'(copy_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check(state == 3'd0, "R9", "idle while stopped", longint'(state), 0);
    run_stop = 1'b0;

    // directed: ramp, trigger on value above level
    build(0, 7);
    capture(0, 5, 100, 1'b0, 1'b1, "R3");
    // exact equality triggers
    capture(0, 4, 98, 1'b0, 1'b0, "R5");
    // column 0: post-trigger only
    build(1, 0);
    capture(0, 0, 128, 1'b0, 1'b0, "R4");
    // last column: straight to copy
    build(0, 9);
    capture(0, DEPTH - 1, 60, 1'b0, 1'b0, "R6");
    // out-of-range column clamped
    capture(0, DEPTH + 1, 61, 1'b0, 1'b0, "R10");
    // slower time base
    build(1, 0);
    capture(1, 7, 200, 1'b0, 1'b1, "R1");

    // random frames
    for (int it = 0; it < 6; it++) begin
      int kind, step, col, lvl, code;
      kind = int'($urandom_range(1, 0));
      step = int'($urandom_range(19, 3));
      col  = int'($urandom_range(DEPTH - 1, 0));
      lvl  = int'($urandom_range(240, 10));
      code = int'($urandom_range(1, 0));
      build(kind, step);
      capture(code, col, lvl, 1'b0, 1'b0, "R3");
    end

    // single mode parks, then releases when the mode falls
    build(0, 11);
    capture(0, 3, 150, 1'b1, 1'b0, "R8");
    repeat (3 * HOLDOFF) @(posedge clk);
    #1;
    check(state == 3'd4, "R8", "single mode parked", longint'(state), 4);
    single_mode = 1'b0;
    @(posedge clk); #1;
    check(state == 3'd0, "R8", "release from single mode", longint'(state), 0);
    repeat (5) @(posedge clk);
    #1;
    check(state == 3'd1, "R10", "counting state code", longint'(state), 1);
    run_stop = 1'b1;
    @(posedge clk); #1;
    check(state == 3'd0, "R9", "stop forces idle", longint'(state), 0);
    repeat (4) @(posedge clk);
    #1;
    check(state == 3'd0, "R9", "idle held while stopped", longint'(state), 0);
    run_stop = 1'b0;
    repeat (5) @(posedge clk);
    #1 cfg_chg = 1'b1;
    @(posedge clk); #1 cfg_chg = 1'b0;
    check(state == 3'd0, "R9", "settings pulse forces idle", longint'(state), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule